// File: doc/BRIEF.md
# Transmit Descriptor Ring DMA Reader

This block walks a ring of 16-byte transmit descriptors held in host memory. A poll-demand strobe starts the walk at the current ring index. For each hardware-owned descriptor it fetches the control and pointer words, gathers the referenced buffer bytes into a local frame store of up to 2048 bytes, and, when the descriptor closes a frame, plays the whole gathered frame out on a byte stream. Each descriptor is then handed back to software by clearing its ownership bit in memory, optional status pulses fire, and the index moves on or wraps. The walk ends at the first descriptor that software still owns, which raises a no-buffer pulse.

All memory traffic uses one word-wide request/acknowledge master port with a single outstanding access. The ring base address and the two enable bits come from the surrounding controller. A poll that arrives while a walk runs is remembered and starts a new walk as soon as the current one stops.

Top module: `txring_dma`

## Requirements
- R1: After reset the ring index is 0 and no request, stream byte or status pulse is active. A poll starts a walk only while `tx_en` and `dma_en` are both 1; the first access is a read of word 0 at `ring_base + index*16`. A poll seen while either enable is 0 and no walk runs is dropped and causes no memory access, not even after the enables return.
- R2: When word 0 bit 31 (ownership, 1 = hardware) reads 0, the walk stops, `stat_no_buf` pulses for one cycle, nothing is written back and the index keeps its value, so the next walk rereads the same descriptor.
- R3: Word 1 holds the byte count in bits [10:0], frame-end in bit 27, frame-start in bit 28, ok-request in bit 29, done-request in bit 30 and ring-wrap in bit 31; word 2 holds a byte address of any alignment. Buffer bytes are taken in rising address order; within a memory word bits [7:0] hold the lowest address.
- R4: A descriptor with frame-start set empties the gather store before its bytes are added; without it, its bytes are appended after whatever the store already holds, even after that content was sent.
- R5: A descriptor with frame-end set sends all gathered bytes, one per cycle with `frm_valid` high and `frm_last` high on the final byte; when nothing is gathered no byte is sent.
- R6: After each hardware-owned descriptor, word 0 is written back with bit 31 cleared and bits [30:0] as read; after that write, ok-request set gives one `stat_xmit_ok` pulse and done-request set gives one `stat_xmit_done` pulse.
- R7: After the write-back the index becomes 0 when ring-wrap is set and index+1 otherwise, and the walk continues with the next descriptor.
- R8: Bytes beyond 2048 in one gather are dropped; the sent frame is then 2048 bytes long and `frm_err` is high with its last byte, otherwise `frm_err` is 0. Frame-start clears the overflow mark.
- R9: A poll that arrives during a walk is latched; once the walk stops, a new walk starts at the current index if both enables are set.
- R10: `mem_req` stays high with `mem_addr`, `mem_we` and `mem_wdata` stable until the cycle `mem_ack` is seen.
- R11: If an enable drops during a walk, the descriptor in progress completes (including its frame and write-back) and the walk then stops without a no-buffer pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_en | input | 1 | Transmit enable |
| dma_en | input | 1 | Transmit DMA enable |
| poll | input | 1 | One-cycle poll-demand strobe |
| ring_base | input | ADDR_W | Byte address of ring slot 0 (16-byte aligned) |
| mem_req | output | 1 | Memory access request, held until acknowledged |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Word-aligned byte address of the access |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | One-cycle acknowledge; read data valid with it |
| mem_rdata | input | 32 | Read data |
| frm_valid | output | 1 | Frame byte valid |
| frm_data | output | 8 | Frame byte |
| frm_last | output | 1 | Final byte of the frame |
| frm_err | output | 1 | Frame was truncated (with last byte) |
| stat_no_buf | output | 1 | Pulse: walk stopped at a software-owned descriptor |
| stat_xmit_ok | output | 1 | Pulse: ok-request descriptor released |
| stat_xmit_done | output | 1 | Pulse: done-request descriptor released |

## Verification
The bench drives random buffer addresses so that segments start and end on every byte lane; a design that took lanes in the wrong order or mishandled the word step would corrupt the compared frame bytes. It chains a descriptor without frame-start after a sent frame, expecting the old bytes to be resent with the new ones, and a two-segment gather of 2052 bytes, where a design without the cap would overrun the store or omit the error flag. It polls during a running walk and expects a second no-buffer pulse from the restarted walk, and drops an enable mid-descriptor, where a wrong design either abandons the descriptor unreleased or keeps walking. Random memory latency shakes out a request that does not hold its address until acknowledged.

// File: rtl/txring_pkg.sv
package txring_pkg;

    localparam int WORD_W     = 32;
    localparam int LANES      = WORD_W / 8;
    localparam int LEN_BITS   = 11;
    localparam int DESC_SHIFT = 4;   // 16-byte descriptors

    // word 0 / word 1 bit positions
    localparam int OWN_POS    = 31;
    localparam int WRAP_POS   = 31;
    localparam int DONEQ_POS  = 30;
    localparam int OKQ_POS    = 29;
    localparam int START_POS  = 28;
    localparam int END_POS    = 27;

    typedef struct packed {
        logic                wrap;
        logic                done_req;
        logic                ok_req;
        logic                frm_start;
        logic                frm_end;
        logic [LEN_BITS-1:0] count;
    } seg_ctl_t;

    typedef enum logic [3:0] {
        WK_IDLE,
        WK_OWN,
        WK_CTL,
        WK_PTR,
        WK_FETCH,
        WK_SPLIT,
        WK_SEND,
        WK_SEND_WAIT,
        WK_RELEASE,
        WK_NEXT
    } walk_st_e;

    function automatic seg_ctl_t unpack_ctl(input logic [WORD_W-1:0] w);
        seg_ctl_t c;
        c.wrap      = w[WRAP_POS];
        c.done_req  = w[DONEQ_POS];
        c.ok_req    = w[OKQ_POS];
        c.frm_start = w[START_POS];
        c.frm_end   = w[END_POS];
        c.count     = w[LEN_BITS-1:0];
        return c;
    endfunction

    function automatic logic [WORD_W-1:0] release_word(input logic [WORD_W-1:0] w);
        logic [WORD_W-1:0] r;
        r          = w;
        r[OWN_POS] = 1'b0;
        return r;
    endfunction

endpackage

// File: rtl/txring_gather.sv
module txring_gather
    import txring_pkg::*;
#(
    parameter int BUF_BYTES = 2048,
    localparam int AW       = $clog2(BUF_BYTES),
    localparam int CNT_W    = AW + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             push,
    input  logic [7:0]       push_byte,
    input  logic [AW-1:0]    rd_idx,
    output logic [7:0]       rd_byte,
    output logic [CNT_W-1:0] fill,
    output logic             ovf
);

    localparam logic [CNT_W-1:0] CAP = CNT_W'(BUF_BYTES);

    logic [7:0]       store [BUF_BYTES];
    logic [CNT_W-1:0] fill_q;
    logic             ovf_q;
    logic             full;

    assign full = (fill_q == CAP);

    always_ff @(posedge clk) begin
        if (rst) begin
            fill_q <= '0;
            ovf_q  <= 1'b0;
        end else if (clr) begin
            fill_q <= '0;
            ovf_q  <= 1'b0;
        end else if (push) begin
            if (full) ovf_q  <= 1'b1;
            else      fill_q <= fill_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (push && !full && !clr) store[fill_q[AW-1:0]] <= push_byte;
    end

    assign rd_byte = store[rd_idx];
    assign fill    = fill_q;
    assign ovf     = ovf_q;

    // R8
    fill_cap_chk: assert property (@(posedge clk) disable iff (rst)
        fill_q <= CAP);

    // R8
    ovf_full_chk: assert property (@(posedge clk) disable iff (rst)
        ovf_q |-> full);

endmodule

// File: rtl/txring_emit.sv
module txring_emit
    import txring_pkg::*;
#(
    parameter int BUF_BYTES = 2048,
    localparam int AW       = $clog2(BUF_BYTES),
    localparam int CNT_W    = AW + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [CNT_W-1:0] total,
    input  logic             trunc,
    input  logic [7:0]       src_byte,
    output logic [AW-1:0]    src_idx,
    output logic             busy,
    output logic             frm_valid,
    output logic [7:0]       frm_data,
    output logic             frm_last,
    output logic             frm_err
);

    logic [CNT_W-1:0] pos_q;
    logic [CNT_W-1:0] total_q;
    logic             busy_q;
    logic             at_end;

    assign at_end = busy_q && (pos_q == total_q - 1'b1);

    always_ff @(posedge clk) begin
        if (rst) begin
            pos_q   <= '0;
            total_q <= '0;
            busy_q  <= 1'b0;
        end else if (start) begin
            pos_q   <= '0;
            total_q <= total;
            busy_q  <= (total != '0);
        end else if (busy_q) begin
            pos_q <= pos_q + 1'b1;
            if (at_end) busy_q <= 1'b0;
        end
    end

    assign src_idx   = pos_q[AW-1:0];
    assign busy      = busy_q;
    assign frm_valid = busy_q;
    assign frm_data  = busy_q ? src_byte : 8'h00;
    assign frm_last  = at_end;
    assign frm_err   = at_end && trunc;

    // R5
    last_in_frame_chk: assert property (@(posedge clk) disable iff (rst)
        frm_last |-> frm_valid);

    // R8
    err_on_last_chk: assert property (@(posedge clk) disable iff (rst)
        frm_err |-> frm_last);

endmodule

// File: rtl/txring_ctrl.sv
module txring_ctrl
    import txring_pkg::*;
#(
    parameter int ADDR_W = 32,
    localparam int IDX_W = ADDR_W - DESC_SHIFT
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tx_en,
    input  logic              dma_en,
    input  logic              poll,
    input  logic [ADDR_W-1:0] ring_base,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              g_clr,
    output logic              g_push,
    output logic [7:0]        g_byte,
    output logic              em_start,
    input  logic              em_busy,
    output logic              stat_no_buf,
    output logic              stat_xmit_ok,
    output logic              stat_xmit_done
);

    localparam logic [ADDR_W-1:0] OFS_CTL = ADDR_W'(4);
    localparam logic [ADDR_W-1:0] OFS_PTR = ADDR_W'(8);
    localparam logic [ADDR_W-1:0] STEP    = ADDR_W'(LANES);
    localparam int                LANE_W  = $clog2(LANES);

    walk_st_e              st_q;
    logic [IDX_W-1:0]      idx_q;
    logic [WORD_W-1:0]     own_w_q;
    seg_ctl_t              ctl_q;
    seg_ctl_t              ctl_rd;
    logic [ADDR_W-1:0]     waddr_q;
    logic [LANE_W-1:0]     lane_q;
    logic [LEN_BITS-1:0]   left_q;
    logic [WORD_W-1:0]     word_q;
    logic                  pend_q;
    logic                  nobuf_q, ok_q, done_q;
    logic                  run_ok;
    logic [ADDR_W-1:0]     desc_addr;

    assign run_ok    = tx_en && dma_en;
    assign desc_addr = ring_base + {idx_q, {DESC_SHIFT{1'b0}}};
    assign ctl_rd    = unpack_ctl(mem_rdata);

    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        unique case (st_q)
            WK_OWN:     begin mem_req = 1'b1; mem_addr = desc_addr; end
            WK_CTL:     begin mem_req = 1'b1; mem_addr = desc_addr + OFS_CTL; end
            WK_PTR:     begin mem_req = 1'b1; mem_addr = desc_addr + OFS_PTR; end
            WK_FETCH:   begin mem_req = 1'b1; mem_addr = waddr_q; end
            WK_RELEASE: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = desc_addr;
                mem_wdata = release_word(own_w_q);
            end
            default: ;
        endcase
    end

    assign g_clr    = (st_q == WK_CTL) && mem_ack && ctl_rd.frm_start;
    assign g_push   = (st_q == WK_SPLIT);
    assign g_byte   = word_q[lane_q*8 +: 8];
    assign em_start = (st_q == WK_SEND);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= WK_IDLE;
            idx_q   <= '0;
            own_w_q <= '0;
            ctl_q   <= '0;
            waddr_q <= '0;
            lane_q  <= '0;
            left_q  <= '0;
            word_q  <= '0;
            pend_q  <= 1'b0;
            nobuf_q <= 1'b0;
            ok_q    <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            nobuf_q <= 1'b0;
            ok_q    <= 1'b0;
            done_q  <= 1'b0;
            if (st_q != WK_IDLE && poll) pend_q <= 1'b1;
            unique case (st_q)
                WK_IDLE: begin
                    pend_q <= 1'b0;
                    if ((poll || pend_q) && run_ok) st_q <= WK_OWN;
                end
                WK_OWN: if (mem_ack) begin
                    if (!mem_rdata[OWN_POS]) begin
                        nobuf_q <= 1'b1;
                        st_q    <= WK_IDLE;
                    end else begin
                        own_w_q <= mem_rdata;
                        st_q    <= WK_CTL;
                    end
                end
                WK_CTL: if (mem_ack) begin
                    ctl_q <= ctl_rd;
                    st_q  <= WK_PTR;
                end
                WK_PTR: if (mem_ack) begin
                    waddr_q <= {mem_rdata[ADDR_W-1:LANE_W], {LANE_W{1'b0}}};
                    lane_q  <= mem_rdata[LANE_W-1:0];
                    left_q  <= ctl_q.count;
                    if (ctl_q.count != '0)  st_q <= WK_FETCH;
                    else if (ctl_q.frm_end) st_q <= WK_SEND;
                    else                    st_q <= WK_RELEASE;
                end
                WK_FETCH: if (mem_ack) begin
                    word_q <= mem_rdata;
                    st_q   <= WK_SPLIT;
                end
                WK_SPLIT: begin
                    left_q <= left_q - 1'b1;
                    lane_q <= lane_q + 1'b1;
                    if (left_q == LEN_BITS'(1)) begin
                        st_q <= ctl_q.frm_end ? WK_SEND : WK_RELEASE;
                    end else if (lane_q == LANE_W'(LANES - 1)) begin
                        waddr_q <= waddr_q + STEP;
                        st_q    <= WK_FETCH;
                    end
                end
                WK_SEND:      st_q <= WK_SEND_WAIT;
                WK_SEND_WAIT: if (!em_busy) st_q <= WK_RELEASE;
                WK_RELEASE: if (mem_ack) begin
                    ok_q   <= ctl_q.ok_req;
                    done_q <= ctl_q.done_req;
                    idx_q  <= ctl_q.wrap ? '0 : idx_q + 1'b1;
                    st_q   <= WK_NEXT;
                end
                WK_NEXT: st_q <= run_ok ? WK_OWN : WK_IDLE;
                default: st_q <= WK_IDLE;
            endcase
        end
    end

    assign stat_no_buf    = nobuf_q;
    assign stat_xmit_ok   = ok_q;
    assign stat_xmit_done = done_q;

    // R10
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                                   && $stable(mem_wdata)));

    // R1
    idle_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == WK_IDLE && !run_ok) |=> !mem_req);

    // R2
    nobuf_keep_idx_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == WK_OWN && mem_ack && !mem_rdata[OWN_POS]) |=> ($stable(idx_q) && stat_no_buf));

    // R7
    wrap_idx_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == WK_RELEASE && mem_ack && ctl_q.wrap) |=> (idx_q == '0));

    // R11
    stop_no_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == WK_NEXT && !run_ok) |=> (st_q == WK_IDLE && !stat_no_buf));

endmodule

// File: rtl/txring_dma.sv
module txring_dma
    import txring_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int BUF_BYTES = 2048
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tx_en,
    input  logic              dma_en,
    input  logic              poll,
    input  logic [ADDR_W-1:0] ring_base,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic              mem_ack,
    input  logic [31:0]       mem_rdata,
    output logic              frm_valid,
    output logic [7:0]        frm_data,
    output logic              frm_last,
    output logic              frm_err,
    output logic              stat_no_buf,
    output logic              stat_xmit_ok,
    output logic              stat_xmit_done
);

    localparam int AW    = $clog2(BUF_BYTES);
    localparam int CNT_W = AW + 1;

    logic             g_clr, g_push, em_start, em_busy, g_ovf;
    logic [7:0]       g_byte, g_rd_byte;
    logic [AW-1:0]    g_rd_idx;
    logic [CNT_W-1:0] g_fill;

    txring_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk            (clk),
        .rst            (rst),
        .tx_en          (tx_en),
        .dma_en         (dma_en),
        .poll           (poll),
        .ring_base      (ring_base),
        .mem_req        (mem_req),
        .mem_we         (mem_we),
        .mem_addr       (mem_addr),
        .mem_wdata      (mem_wdata),
        .mem_ack        (mem_ack),
        .mem_rdata      (mem_rdata),
        .g_clr          (g_clr),
        .g_push         (g_push),
        .g_byte         (g_byte),
        .em_start       (em_start),
        .em_busy        (em_busy),
        .stat_no_buf    (stat_no_buf),
        .stat_xmit_ok   (stat_xmit_ok),
        .stat_xmit_done (stat_xmit_done)
    );

    txring_gather #(.BUF_BYTES(BUF_BYTES)) u_gather (
        .clk       (clk),
        .rst       (rst),
        .clr       (g_clr),
        .push      (g_push),
        .push_byte (g_byte),
        .rd_idx    (g_rd_idx),
        .rd_byte   (g_rd_byte),
        .fill      (g_fill),
        .ovf       (g_ovf)
    );

    txring_emit #(.BUF_BYTES(BUF_BYTES)) u_emit (
        .clk       (clk),
        .rst       (rst),
        .start     (em_start),
        .total     (g_fill),
        .trunc     (g_ovf),
        .src_byte  (g_rd_byte),
        .src_idx   (g_rd_idx),
        .busy      (em_busy),
        .frm_valid (frm_valid),
        .frm_data  (frm_data),
        .frm_last  (frm_last),
        .frm_err   (frm_err)
    );

endmodule

// File: tb/txring_dma_tb.sv
module txring_dma_tb_top;

    localparam logic [31:0] RB = 32'h0000_0100;
    localparam logic [31:0] DB = 32'h0000_8000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tx_en = 1'b0, dma_en = 1'b0, poll = 1'b0;
    logic        mem_req, mem_we, mem_ack;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic        frm_valid, frm_last, frm_err;
    logic [7:0]  frm_data;
    logic        stat_no_buf, stat_xmit_ok, stat_xmit_done;

    always #5 clk = ~clk;

    txring_dma dut_i (
        .clk(clk), .rst(rst), .tx_en(tx_en), .dma_en(dma_en), .poll(poll),
        .ring_base(RB), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .frm_valid(frm_valid), .frm_data(frm_data), .frm_last(frm_last),
        .frm_err(frm_err), .stat_no_buf(stat_no_buf), .stat_xmit_ok(stat_xmit_ok),
        .stat_xmit_done(stat_xmit_done)
    );

    // ---------------- memory model ----------------
    logic [31:0] dmem [0:31];
    logic        bw_en = 1'b0;
    logic [4:0]  bw_a = '0;
    logic [31:0] bw_d = '0;
    int          lat = 0;
    int          acc_cnt = 0;
    int          viol = 0;
    logic [31:0] last_own_addr = '0;
    logic        hold_v = 1'b0;
    logic [31:0] hold_a = '0;
    logic        hold_we = 1'b0;

    function automatic logic [7:0] dbyte(input logic [31:0] a);
        return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h5A;
    endfunction

    function automatic bit in_desc(input logic [31:0] a);
        return (a >= RB) && (a < RB + 32'd128);
    endfunction

    function automatic logic [31:0] rd_word(input logic [31:0] a);
        logic [31:0] w;
        if (in_desc(a)) w = dmem[5'((a - RB) >> 2)];
        else if (a >= DB) w = {dbyte(a + 3), dbyte(a + 2), dbyte(a + 1), dbyte(a)};
        else w = 32'h0;
        return w;
    endfunction

    initial for (int i = 0; i < 32; i++) dmem[i] = 32'h0;

    always @(posedge clk) begin
        mem_ack <= 1'b0;
        if (bw_en) dmem[bw_a] <= bw_d;
        if (hold_v && (!mem_req || mem_addr != hold_a || mem_we != hold_we)) viol <= viol + 1;
        hold_v  <= mem_req && !mem_ack;
        hold_a  <= mem_addr;
        hold_we <= mem_we;
        if (rst) begin
            lat <= 0;
        end else if (mem_req && !mem_ack) begin
            if (lat == 0) begin
                mem_ack <= 1'b1;
                lat     <= $urandom_range(0, 2);
                acc_cnt <= acc_cnt + 1;
                if (mem_we) begin
                    if (in_desc(mem_addr)) dmem[5'((mem_addr - RB) >> 2)] <= mem_wdata;
                end else begin
                    mem_rdata <= rd_word(mem_addr);
                    if (in_desc(mem_addr) && mem_addr[3:0] == 4'h0) last_own_addr <= mem_addr;
                end
            end else begin
                lat <= lat - 1;
            end
        end
    end

    // ---------------- output monitor ----------------
    logic [7:0] got [0:2047];
    int gcnt = 0, frames = 0, fr_len = 0, n_nobuf = 0, n_ok = 0, n_done = 0;
    logic fr_err = 1'b0;

    always @(negedge clk) begin
        if (!rst) begin
            if (frm_valid) begin
                if (gcnt < 2048) got[gcnt] = frm_data;
                gcnt = gcnt + 1;
                if (frm_last) begin
                    fr_len = gcnt; fr_err = frm_err; frames = frames + 1; gcnt = 0;
                end
            end
            if (stat_no_buf)    n_nobuf = n_nobuf + 1;
            if (stat_xmit_ok)   n_ok    = n_ok + 1;
            if (stat_xmit_done) n_done  = n_done + 1;
        end
    end

    // ---------------- bench model / checks ----------------
    int checks = 0, failures = 0;
    bit finished = 1'b0;
    logic [7:0] eg [0:2047];
    int eg_len = 0;
    bit eg_ovf = 1'b0;
    int bidx = 0;
    int efr = 0, eok = 0, edone = 0;
    int s_frames = 0, s_ok = 0, s_done = 0, s_nobuf = 0, s_acc = 0;
    int wslot [0:15];
    logic [31:0] wexp [0:15];
    int nw = 0;

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic wr_desc(input int a, input logic [31:0] d);
        bw_en = 1'b1; bw_a = 5'(a); bw_d = d;
        @(negedge clk);
        bw_en = 1'b0;
    endtask

    task automatic add_seg(input bit first, input bit last, input bit okq, input bit doneq,
                           input int len, input logic [31:0] buff);
        logic [31:0] w0, w1;
        w0 = 32'h8000_0000 | (32'(bidx) << 8) | 32'h5C;
        w1 = ((bidx == 7) ? 32'h8000_0000 : 32'h0) | (32'(doneq) << 30) | (32'(okq) << 29)
           | (32'(first) << 28) | (32'(last) << 27) | 32'(len);
        wr_desc(bidx * 4 + 0, w0);
        wr_desc(bidx * 4 + 1, w1);
        wr_desc(bidx * 4 + 2, buff);
        wr_desc(bidx * 4 + 3, 32'h0);
        wslot[nw] = bidx; wexp[nw] = w0 & 32'h7FFF_FFFF; nw++;
        if (first) begin eg_len = 0; eg_ovf = 1'b0; end
        for (int i = 0; i < len; i++) begin
            if (eg_len < 2048) begin eg[eg_len] = dbyte(buff + 32'(i)); eg_len++; end
            else eg_ovf = 1'b1;
        end
        if (okq) eok++;
        if (doneq) edone++;
        if (last && eg_len > 0) efr++;
        bidx = (bidx + 1) % 8;
    endtask

    task automatic close_ring();
        wr_desc(bidx * 4, 32'h0);
    endtask

    task automatic begin_scn();
        s_frames = frames; s_ok = n_ok; s_done = n_done; s_nobuf = n_nobuf; s_acc = acc_cnt;
        efr = 0; eok = 0; edone = 0; nw = 0;
    endtask

    task automatic pulse_poll();
        poll = 1'b1;
        @(negedge clk);
        poll = 1'b0;
    endtask

    task automatic wait_nobuf(input int target);
        for (int i = 0; i < 30000 && n_nobuf < target; i++) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    task automatic check_walk(input int exp_nobuf);
        int bad, first_bad;
        chk(frames - s_frames == efr, "R5", "frame count", frames - s_frames, efr);
        if (efr > 0) begin
            chk(fr_len == eg_len, "R5", "frame length", fr_len, eg_len);
            bad = 0; first_bad = -1;
            for (int i = 0; i < eg_len && i < 2048; i++)
                if (got[i] !== eg[i]) begin bad++; if (first_bad < 0) first_bad = i; end
            chk(bad == 0, "R3", "frame byte mismatches (first index as actual)", first_bad, -1);
            chk(fr_err == eg_ovf, "R8", "frame error flag", int'(fr_err), int'(eg_ovf));
        end
        chk(n_ok - s_ok == eok, "R6", "ok pulses", n_ok - s_ok, eok);
        chk(n_done - s_done == edone, "R6", "done pulses", n_done - s_done, edone);
        chk(n_nobuf - s_nobuf == exp_nobuf, "R2", "no-buffer pulses", n_nobuf - s_nobuf, exp_nobuf);
        chk(last_own_addr == RB + 32'(bidx * 16), "R7", "stop descriptor address",
            int'(last_own_addr), int'(RB + 32'(bidx * 16)));
        for (int k = 0; k < nw; k++)
            chk(dmem[wslot[k] * 4] == wexp[k], "R6", "released word 0",
                int'(dmem[wslot[k] * 4]), int'(wexp[k]));
        chk(viol == 0, "R10", "request held until ack", viol, 0);
    endtask

    initial begin
        void'($urandom(32'h00C0FFEE));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(!mem_req && !frm_valid && !stat_no_buf && !stat_xmit_ok && !stat_xmit_done,
            "R1", "outputs idle after reset", int'(mem_req), 0);

        // R1 poll dropped while disabled
        begin_scn();
        tx_en = 1'b0; dma_en = 1'b1;
        pulse_poll();
        tx_en = 1'b1; dma_en = 1'b0;
        pulse_poll();
        repeat (20) @(negedge clk);
        dma_en = 1'b1;
        repeat (20) @(negedge clk);
        chk(acc_cnt == s_acc, "R1", "accesses after disabled polls", acc_cnt - s_acc, 0);

        // R1/R5/R6: single-descriptor frame, first walk from slot 0
        begin_scn();
        add_seg(1, 1, 1, 1, 10, DB + 32'h40);
        close_ring();
        pulse_poll();
        wait_nobuf(s_nobuf + 1);
        check_walk(1);

        // R3/R4: three segments at odd alignments
        begin_scn();
        add_seg(1, 0, 0, 1, 7, DB + 32'h101);
        add_seg(0, 0, 1, 0, 5, DB + 32'h222);
        add_seg(0, 1, 0, 0, 9, DB + 32'h343);
        close_ring();
        pulse_poll();
        wait_nobuf(s_nobuf + 1);
        check_walk(1);

        // R4: append without frame-start after a sent frame
        begin_scn();
        add_seg(0, 1, 0, 0, 3, DB + 32'h503);
        close_ring();
        pulse_poll();
        wait_nobuf(s_nobuf + 1);
        check_walk(1);
        chk(fr_len == 24, "R4", "appended frame length", fr_len, 24);

        // R5: zero-length frame sends nothing; R7 wrap happens around here too
        begin_scn();
        add_seg(1, 1, 0, 0, 0, DB);
        close_ring();
        pulse_poll();
        wait_nobuf(s_nobuf + 1);
        check_walk(1);

        // R8: overflow of the 2048-byte store
        begin_scn();
        add_seg(1, 0, 0, 0, 2047, DB + 32'h1001);
        add_seg(0, 1, 1, 1, 5, DB + 32'h3002);
        close_ring();
        pulse_poll();
        wait_nobuf(s_nobuf + 1);
        check_walk(1);
        chk(fr_len == 2048 && fr_err, "R8", "truncated frame length", fr_len, 2048);

        // R9: poll during a walk is latched and restarts it
        begin_scn();
        add_seg(1, 1, 0, 0, 120, DB + 32'h602);
        close_ring();
        pulse_poll();
        repeat (10) @(negedge clk);
        pulse_poll();
        wait_nobuf(s_nobuf + 2);
        repeat (30) @(negedge clk);
        check_walk(2);
        chk(n_nobuf - s_nobuf == 2, "R9", "restarted walk stop count", n_nobuf - s_nobuf, 2);

        // R11: enable dropped mid-descriptor
        begin_scn();
        add_seg(1, 1, 0, 0, 40, DB + 32'h700);
        add_seg(1, 1, 0, 1, 8, DB + 32'h780);
        close_ring();
        pulse_poll();
        repeat (15) @(negedge clk);
        tx_en = 1'b0;
        repeat (300) @(negedge clk);
        chk(frames - s_frames == 1 && fr_len == 40, "R11", "frame of interrupted walk", fr_len, 40);
        chk(n_nobuf == s_nobuf, "R11", "no-buffer pulse on enable drop", n_nobuf - s_nobuf, 0);
        chk(dmem[wslot[1] * 4][31] == 1'b1, "R11", "next descriptor untouched",
            int'(dmem[wslot[1] * 4][31]), 1);
        tx_en = 1'b1;
        pulse_poll();
        wait_nobuf(s_nobuf + 1);
        check_walk(1);

        // random walks: R3 R4 R5 R6 R7
        for (int it = 0; it < 14; it++) begin
            int nseg;
            begin_scn();
            nseg = $urandom_range(1, 3);
            for (int s = 0; s < nseg; s++)
                add_seg(s == 0, s == nseg - 1, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                        $urandom_range(0, 60), DB + 32'($urandom_range(0, 4000)));
            close_ring();
            pulse_poll();
            wait_nobuf(s_nobuf + 1);
            check_walk(1);
        end

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (180000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule